// File: doc/BRIEF.md
# Split-Read Cycle Counter with Tear Detection

This block is a free-running cycle counter, parameterised in width (64 bits by default), that a narrower register bus reads in two halves. It has three registers: a control word, a lower-half register and an upper-half register. Writing 1 to bit 0 of the control word starts the count, and writing 0 stops it. Once started, the counter advances by one on every clock and wraps to zero after its all-ones value.

The two halves cannot be sampled in the same bus cycle, so the block watches the order of reads. A read of the lower half opens a tracking window and records the upper half as it stood at that moment. The next read of the upper half closes the window. Software then reads the control word. Its top bit is 1 only if three things hold: the pair followed this order, the upper half did not change between the two reads, and no interrupt or exception was signalled on `intr_taken` while the window was open. Software repeats the lower, upper, control sequence until that bit reads 1.

Reads return data combinationally in the cycle in which `rd_en` is high. Each read also updates the tracking state at the closing clock edge.

Top module: `split_rd_counter`

## Requirements
- R1: After reset the counter is zero and counting is disabled. The control word, the lower half and the upper half all read 0.
- R2: A write to the control address sets the enable from `wdata[0]`. While enabled, the counter rises by exactly one per clock, starting on the clock after the write. While disabled, it holds its value.
- R3: The counter is CNT_W bits wide and runs without a limit. The value after all ones is zero.
- R4: Address 0x103 selects the control word, 0x104 the lower half (counter bits CNT_W/2-1:0) and 0x105 the upper half (the remaining bits). Half values are zero-extended to the bus width. Any other address, or no read strobe, returns 0.
- R5: In the control word, bit 0 reads back the enable and bits BUS_W-2:1 read 0.
- R6: A lower-half read opens a new window and clears any earlier tear. If an upper-half read follows with no tear, control bit BUS_W-1 then reads 1.
- R7: If `intr_taken` is high in any cycle after the lower-half read, up to and including the cycle of the upper-half read, the status bit reads 0. A pulse while no window is open has no effect.
- R8: If the upper half returned by the upper-half read differs from its value at the lower-half read, the status bit reads 0.
- R9: An upper-half read with no lower-half read since the last upper-half read, or since reset, makes the status bit read 0.
- R10: After the pair closes, control reads and `intr_taken` pulses leave the status bit unchanged. Writes to the lower-half and upper-half addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe for the register at `addr` |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W | Register address |
| wdata | input | BUS_W | Write data; only bit 0 of the control word is stored |
| intr_taken | input | 1 | High in a cycle in which the processor takes an interrupt or exception |
| rdata | output | BUS_W | Read data, valid in the cycle of `rd_en` |

## Verification
The bench uses a 16-bit counter, so the carry from the lower half into the upper half comes every 256 cycles and the full wrap fits in the run. It aligns lower and upper reads to straddle each carry with gaps of zero to two cycles. A design that compared the wrong samples would report such a pair as coherent, or would flag a clean pair as torn. With the counter stopped, it places interrupt pulses before the window, inside it and on the upper-read cycle itself. It also issues upper reads with no preceding lower read. A tracker with an off-by-one window edge, or one that left a stale state after the pair closed, shows a wrong status bit. Writes to the half registers and reads of unmapped addresses confirm that nothing leaks into the count or onto the bus.

// File: rtl/sprd_pkg.sv
package sprd_pkg;

   // Tracking window of the split read
   typedef enum logic [1:0] {
      TRK_IDLE   = 2'd0,   // no lower-half read seen
      TRK_ARMED  = 2'd1,   // lower half read, waiting for upper half
      TRK_PAIRED = 2'd2    // pair closed, status is final
   } trk_state_e;

   typedef struct packed {
      logic ctrl;
      logic lo;
      logic hi;
   } reg_sel_t;

endpackage

// File: rtl/sprd_addr_dec.sv
module sprd_addr_dec
   import sprd_pkg::*;
#(
   parameter int              ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h103,
   parameter logic [ADDR_W-1:0] LO_ADDR   = 'h104,
   parameter logic [ADDR_W-1:0] HI_ADDR   = 'h105
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);

   generate
      if (CTRL_ADDR == LO_ADDR || CTRL_ADDR == HI_ADDR || LO_ADDR == HI_ADDR) begin : g_bad_map
         $error("sprd_addr_dec: register addresses must be distinct");
      end
   endgenerate

   assign sel.ctrl = (addr == CTRL_ADDR);
   assign sel.lo   = (addr == LO_ADDR);
   assign sel.hi   = (addr == HI_ADDR);

endmodule

// File: rtl/sprd_count_core.sv
module sprd_count_core #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr,
   input  logic             en_wdata,
   output logic             en,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en  <= 1'b0;
         cnt <= '0;
      end else begin
         if (en_wr) en <= en_wdata;
         if (en)    cnt <= cnt + 1'b1;
      end
   end

   AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> (en == $past(en_wdata)));                          // R2
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (cnt == CNT_W'($past(cnt) + 1'b1)));                   // R3
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt));                                        // R2

endmodule

// File: rtl/sprd_read_tracker.sv
module sprd_read_tracker
   import sprd_pkg::*;
#(
   parameter int HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_lo,
   input  logic              rd_hi,
   input  logic              irq,
   input  logic [HALF_W-1:0] hi_now,
   output logic              coherent
);

   trk_state_e        state;
   logic              torn;
   logic [HALF_W-1:0] hi_snap;
   logic              hi_moved;

   assign hi_moved = (hi_now != hi_snap);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= TRK_IDLE;
         torn    <= 1'b0;
         hi_snap <= '0;
      end else if (rd_lo) begin
         state   <= TRK_ARMED;
         torn    <= 1'b0;
         hi_snap <= hi_now;
      end else if (rd_hi) begin
         state <= TRK_PAIRED;
         torn  <= torn | irq | hi_moved | (state != TRK_ARMED);
      end else if (state == TRK_ARMED && irq) begin
         torn <= 1'b1;
      end
   end

   assign coherent = (state == TRK_PAIRED) && !torn;

   AST_LO_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> (state == TRK_ARMED && !torn));                     // R6
   AST_IRQ_TEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TRK_ARMED && irq && !rd_lo) |=> torn);              // R7
   AST_HI_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TRK_ARMED && rd_hi && !rd_lo && hi_moved) |=> !coherent); // R8
   AST_HI_ORPHAN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hi && !rd_lo && state != TRK_ARMED) |=> !coherent);       // R9
   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TRK_PAIRED && !rd_lo && !rd_hi) |=> $stable(coherent)); // R10

endmodule

// File: rtl/split_rd_counter.sv
module split_rd_counter
   import sprd_pkg::*;
#(
   parameter int                CNT_W     = 64,
   parameter int                BUS_W     = 32,
   parameter int                ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h103,
   parameter logic [ADDR_W-1:0] LO_ADDR   = 'h104,
   parameter logic [ADDR_W-1:0] HI_ADDR   = 'h105
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              intr_taken,
   output logic [BUS_W-1:0]  rdata
);

   localparam int HALF_W = CNT_W / 2;

   generate
      if (CNT_W % 2 != 0 || HALF_W > BUS_W || BUS_W < 2) begin : g_bad_width
         $error("split_rd_counter: CNT_W must be even and CNT_W/2 must fit in BUS_W >= 2");
      end
   endgenerate

   reg_sel_t          sel;
   logic              en;
   logic [CNT_W-1:0]  cnt;
   logic              coherent;
   logic [BUS_W-1:0]  lo_word;
   logic [BUS_W-1:0]  hi_word;
   logic [BUS_W-1:0]  ctrl_word;
   logic              unused_wdata_bits;

   assign unused_wdata_bits = ^wdata[BUS_W-1:1];

   sprd_addr_dec #(
      .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
   ) u_dec (
      .addr (addr),
      .sel  (sel)
   );

   sprd_count_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr    (wr_en && sel.ctrl),
      .en_wdata (wdata[0]),
      .en       (en),
      .cnt      (cnt)
   );

   sprd_read_tracker #(.HALF_W(HALF_W)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_lo    (rd_en && sel.lo),
      .rd_hi    (rd_en && sel.hi),
      .irq      (intr_taken),
      .hi_now   (cnt[CNT_W-1:HALF_W]),
      .coherent (coherent)
   );

   generate
      if (HALF_W < BUS_W) begin : g_pad
         assign lo_word = {{(BUS_W-HALF_W){1'b0}}, cnt[HALF_W-1:0]};
         assign hi_word = {{(BUS_W-HALF_W){1'b0}}, cnt[CNT_W-1:HALF_W]};
      end else begin : g_exact
         assign lo_word = cnt[HALF_W-1:0];
         assign hi_word = cnt[CNT_W-1:HALF_W];
      end
   endgenerate

   assign ctrl_word = {coherent, {(BUS_W-2){1'b0}}, en};

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (sel.ctrl)    rdata = ctrl_word;
         else if (sel.lo) rdata = lo_word;
         else if (sel.hi) rdata = hi_word;
      end
   end

   AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en || !(sel.ctrl || sel.lo || sel.hi)) |-> (rdata == '0)); // R4
   AST_HALF_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sel.ctrl) |=> (en == $past(en)));                  // R10

endmodule

// File: tb/split_rd_counter_tb.sv
`timescale 1ns/1ps
module split_rd_counter_tb;

   localparam int CNT_W = 16;
   localparam int BUS_W = 32;
   localparam logic [11:0] A_CTRL = 12'h103;
   localparam logic [11:0] A_LO   = 12'h104;
   localparam logic [11:0] A_HI   = 12'h105;
   localparam logic [31:0] OK_BIT = 32'h8000_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_en = 1'b0;
   logic              wr_en = 1'b0;
   logic [11:0]       addr = '0;
   logic [BUS_W-1:0]  wdata = '0;
   logic              intr_taken = 1'b0;
   logic [BUS_W-1:0]  rdata;

   int checks = 0;
   int errors = 0;

   logic [CNT_W-1:0] m = '0;
   logic             m_en = 1'b0;

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n)    m <= '0;
      else if (m_en) m <= m + 1'b1;
   end

   split_rd_counter #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(12)) u_dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .intr_taken(intr_taken), .rdata(rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, input bit irq_same,
                     output logic [31:0] d, output logic [CNT_W-1:0] mm);
      @(negedge clk);
      addr = a; rd_en = 1'b1; intr_taken = irq_same;
      #1 d = rdata; mm = m;
      @(posedge clk);
      #1 rd_en = 1'b0; intr_taken = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      #1 wr_en = 1'b0;
      if (a == A_CTRL) m_en = d[0];
   endtask

   task automatic pulse_irq();
      @(negedge clk);
      intr_taken = 1'b1;
      @(posedge clk);
      #1 intr_taken = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   // lower, optional gap, upper, control; expected computed from the model
   task automatic pair_check(input int gap, output bit was_ok);
      logic [31:0] dl, dh, dc;
      logic [CNT_W-1:0] ml, mh, mc;
      rd(A_LO, 1'b0, dl, ml);
      idle(gap);
      rd(A_HI, 1'b0, dh, mh);
      rd(A_CTRL, 1'b0, dc, mc);
      chk("R4 lower half", dl, {24'h0, ml[7:0]});
      chk("R4 upper half", dh, {24'h0, mh[15:8]});
      was_ok = (ml[15:8] == mh[15:8]);
      chk("R8 status vs carry", dc, (was_ok ? OK_BIT : 32'h0) | {31'h0, m_en});
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d, d2;
      logic [CNT_W-1:0] mm;
      bit ok;
      int n_ok, n_torn;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, 1'b0, d, mm); chk("R1 ctrl after reset", d, 32'h0);
      rd(A_LO, 1'b0, d, mm);   chk("R1 lower after reset", d, 32'h0);
      // R9: upper read right after a lower read is fine, so start clean with an orphan
      rd(A_HI, 1'b0, d, mm);   chk("R1 upper after reset", d, 32'h0);
      rd(A_HI, 1'b0, d, mm);
      rd(A_CTRL, 1'b0, d, mm); chk("R9 second upper read without lower", d, 32'h0);

      // R6 clean pair with counter stopped
      rd(A_LO, 1'b0, d, mm); rd(A_HI, 1'b0, d, mm);
      rd(A_CTRL, 1'b0, d, mm); chk("R6 clean pair", d, OK_BIT);

      // R10: pulse after close and repeated control reads keep status
      pulse_irq();
      rd(A_CTRL, 1'b0, d, mm); chk("R10 irq after close", d, OK_BIT);
      rd(A_CTRL, 1'b0, d, mm); chk("R10 repeated ctrl read", d, OK_BIT);

      // R7 irq inside the window
      rd(A_LO, 1'b0, d, mm); pulse_irq(); rd(A_HI, 1'b0, d, mm);
      rd(A_CTRL, 1'b0, d, mm); chk("R7 irq between reads", d, 32'h0);
      // R6 a new lower read clears the tear
      rd(A_LO, 1'b0, d, mm); rd(A_HI, 1'b0, d, mm);
      rd(A_CTRL, 1'b0, d, mm); chk("R6 lower read clears tear", d, OK_BIT);
      // R7 irq on the upper-read cycle
      rd(A_LO, 1'b0, d, mm); rd(A_HI, 1'b1, d, mm);
      rd(A_CTRL, 1'b0, d, mm); chk("R7 irq on upper read cycle", d, 32'h0);
      // R7 irq on the lower-read cycle and before the window: no effect
      pulse_irq();
      rd(A_LO, 1'b1, d, mm); rd(A_HI, 1'b0, d, mm);
      rd(A_CTRL, 1'b0, d, mm); chk("R7 irq outside window", d, OK_BIT);
      // R9 upper read after a closed pair
      rd(A_HI, 1'b0, d, mm);
      rd(A_CTRL, 1'b0, d, mm); chk("R9 upper read after closed pair", d, 32'h0);

      // R4 unmapped addresses
      rd(12'h106, 1'b0, d, mm); chk("R4 unmapped 0x106", d, 32'h0);
      rd(12'h003, 1'b0, d, mm); chk("R4 unmapped 0x003", d, 32'h0);

      // R2 enable and step
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd(A_CTRL, 1'b0, d, mm); chk("R5 ctrl readback enabled", d & 32'h7FFF_FFFF, 32'h1);
      rd(A_LO, 1'b0, d, mm);
      idle(9);
      rd(A_LO, 1'b0, d2, mm);
      chk("R2 counts one per clock", d2, (d + 32'd10) & 32'hFF);

      // R10 writes to half registers ignored
      wr(A_CTRL, 32'h0);
      rd(A_LO, 1'b0, d, mm);
      chk("R2 model agrees when stopped", d, {24'h0, mm[7:0]});
      wr(A_LO, 32'hFFFF_FFFF); wr(A_HI, 32'hFFFF_FFFF);
      rd(A_LO, 1'b0, d2, mm); chk("R10 lower write ignored", d2, d);
      rd(A_HI, 1'b0, d2, mm); chk("R10 upper write ignored", d2, {24'h0, mm[15:8]});
      rd(A_CTRL, 1'b0, d, mm); chk("R5 ctrl readback disabled", d & 32'h7FFF_FFFF, 32'h0);
      idle(6);
      rd(A_LO, 1'b0, d2, mm); chk("R2 hold while disabled", d2, {24'h0, mm[7:0]});

      // R8 pairs aligned to straddle carries
      wr(A_CTRL, 32'h1);
      n_ok = 0; n_torn = 0;
      for (int g = 0; g < 3; g++) begin
         for (int j = 1; j < 6; j++) begin
            while (m[7:0] != 8'(256 - j - 2)) @(posedge clk);
            pair_check(g, ok);
            if (ok) n_ok++; else n_torn++;
         end
      end
      // free sweep
      for (int i = 0; i < 200; i++) begin
         pair_check(i % 3, ok);
         if (ok) n_ok++; else n_torn++;
      end
      chk("R8 some pairs torn by carry", 32'(n_torn > 0), 32'h1);
      chk("R6 some pairs coherent", 32'(n_ok > 0), 32'h1);

      // R3 wrap past all ones
      while (m != 16'hFFF0) @(posedge clk);
      rd(A_HI, 1'b0, d, mm); chk("R3 upper before wrap", d, 32'hFF);
      idle(20);
      rd(A_HI, 1'b0, d, mm); chk("R3 upper after wrap", d, 32'h0);
      rd(A_LO, 1'b0, d, mm); chk("R3 lower after wrap", d, {24'h0, mm[7:0]});
      chk("R3 wrapped low value small", 32'(d < 32'h20), 32'h1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule